// File: doc/BRIEF.md
# Serial SPI Static RAM Model

This block behaves as a byte-wide static RAM reached over a single-bit SPI bus in clock mode 0. A host lowers the chip select, shifts in an 8-bit command, and for array accesses a 24-bit address (most significant byte first), then streams data bytes in or out for as long as the select stays low. The SPI pins are sampled by a system clock that runs several times faster than the serial clock, so the whole model lives in one clock domain and can sit beside other logic on a chip or in an emulation build.

A small access-control byte sets how the internal address moves between data bytes while the select stays low. In byte mode a command moves a single byte. In page mode the address wraps inside its 32-byte page. In sequential mode it runs through the whole array and wraps from the last location to zero. An active-low hold input freezes the serial transfer: clock edges are ignored and the data output is released. The array depth is a parameter: `ADDR_BITS` of 18 gives the full 256K x 8 array, and address bits above `ADDR_BITS` are ignored.

Top module: `spi_sram_model`

## Requirements
- R1: After reset the access mode is sequential, so a mode read returns 0x40, and `miso_oe` is low.
- R2: Command 0x02 followed by a 24-bit address writes the following bytes, and command 0x03 reads them, bit 7 first. Address bits at and above `ADDR_BITS` are ignored.
- R3: In sequential mode (mode bits [7:6] = 01), each data byte after the first goes to the next address, across page boundaries.
- R4: In sequential mode the address wraps from location 2^ADDR_BITS-1 to 0.
- R5: In page mode (mode bits [7:6] = 10), only address bits [4:0] advance, so the address wraps within its 32-byte page.
- R6: In byte mode (mode bits [7:6] = 00, and likewise 11), only one data byte is moved per command. Later clocks are ignored until the select rises, and `miso_oe` stays low for them.
- R7: Command 0x01 writes the mode byte and command 0x05 returns it. Only bits [7:6] are kept, and bits [5:0] read as zero.
- R8: Commands 0x3B, 0x38 and 0xFF, and any other unknown command, do nothing. Bytes that follow them change neither the array nor the mode.
- R9: Raising the select aborts any command and returns the block to waiting for a command. A data byte with fewer than 8 bits received is not written.
- R10: While `hold_n` is low, serial clock edges are ignored and `miso_oe` is low. The transfer resumes where it stopped once `hold_n` rises.
- R11: `miso_oe` is high only while a read or mode-read command is returning data with the select low, and it is low during command, address and write phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock (mode 0: idles low) |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in, sampled on the rising edge of SCK |
| hold_n | input | 1 | Active-low transfer pause |
| miso | output | 1 | Serial data out, changes after the falling edge of SCK |
| miso_oe | output | 1 | Output enable for miso (low means high impedance) |

## Verification
The bench builds the block with `ADDR_BITS` = 10, which gives a 1024-byte array of 32 pages. This keeps the last location (0x3FF) and its sequential wrap to zero within a few transfers. It also lets the bench check address aliasing by setting the 14 ignored upper address bits to arbitrary values. With the page size fixed at 32 bytes, page-mode wrap at offset 31 and the crossing of a page boundary in sequential mode are both exercised against the same nearby addresses.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

  typedef enum logic [1:0] {
    AM_BYTE = 2'b00,
    AM_SEQ  = 2'b01,
    AM_PAGE = 2'b10,
    AM_RSVD = 2'b11
  } acc_mode_e;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_RMODE,
    ST_WMODE,
    ST_DONE
  } cmd_state_e;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_RDMODE = 8'h05;
  localparam logic [7:0] OP_WRMODE = 8'h01;

  // one data byte per command in byte mode and in the reserved encoding
  function automatic logic single_shot(acc_mode_e m);
    return (m == AM_BYTE) || (m == AM_RSVD);
  endfunction

endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic       hold_n,
  input  logic [7:0] tx_byte,
  output logic       sel,
  output logic       live,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso_bit
);

  logic       sck_q, sck_p, cs_q, mosi_q, hold_q;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic       sck_rise, sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      sck_p  <= 1'b0;
      cs_q   <= 1'b1;
      mosi_q <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      sck_q  <= sck;
      sck_p  <= sck_q;
      cs_q   <= cs_n;
      mosi_q <= mosi;
      hold_q <= hold_n;
    end
  end

  assign sel      = !cs_q;
  assign live     = !cs_q && hold_q;
  assign sck_rise = live && sck_q && !sck_p;
  assign sck_fall = live && !sck_q && sck_p;

  assign byte_done = sck_rise && (bit_cnt == 3'd7);
  assign rx_byte   = {shreg, mosi_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= 3'd0;
      shreg    <= 7'd0;
      miso_bit <= 1'b0;
    end else if (cs_q) begin
      bit_cnt  <= 3'd0;
      miso_bit <= 1'b0;
    end else begin
      if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        shreg   <= {shreg[5:0], mosi_q};
      end
      if (sck_fall) miso_bit <= tx_byte[~bit_cnt];
    end
  end

  AST_HOLD_FREEZES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && !hold_q) |=> $stable(bit_cnt)); // R10
  AST_BYTE_REALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (bit_cnt == 3'd0)); // R2

endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int ADDR_BITS = 11
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata
);

  localparam int DEPTH = 1 << ADDR_BITS;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/sram_cmd_ctrl.sv
module sram_cmd_ctrl
  import sram_spi_pkg::*;
#(
  parameter int ADDR_BITS = 11,
  parameter int PAGE_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 byte_done,
  input  logic [7:0]           rx_byte,
  input  logic [7:0]           rd_data,
  output logic                 mem_we,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic [7:0]           mem_wdata,
  output logic [7:0]           tx_byte,
  output logic                 talking
);

  cmd_state_e           state;
  acc_mode_e            mode;
  logic [1:0]           abyte_cnt;
  logic                 is_read;
  logic [ADDR_BITS-1:0] cur_addr;

  function automatic logic [ADDR_BITS-1:0] step_addr(logic [ADDR_BITS-1:0] a, acc_mode_e m);
    logic [ADDR_BITS-1:0] r;
    r = a;
    if (m == AM_PAGE) r[PAGE_BITS-1:0] = a[PAGE_BITS-1:0] + 1'b1;
    else              r = a + 1'b1;
    return r;
  endfunction

  assign mem_we    = byte_done && (state == ST_WDATA);
  assign mem_addr  = cur_addr;
  assign mem_wdata = rx_byte;
  assign talking   = (state == ST_RDATA) || (state == ST_RMODE);
  assign tx_byte   = (state == ST_RMODE) ? {mode, 6'd0} : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OPCODE;
      mode      <= AM_SEQ;
      abyte_cnt <= 2'd0;
      is_read   <= 1'b0;
      cur_addr  <= '0;
    end else if (!sel) begin
      state     <= ST_OPCODE;
      abyte_cnt <= 2'd0;
    end else if (byte_done) begin
      unique case (state)
        ST_OPCODE: begin
          abyte_cnt <= 2'd0;
          case (rx_byte)
            OP_READ:   begin state <= ST_ADDR; is_read <= 1'b1; end
            OP_WRITE:  begin state <= ST_ADDR; is_read <= 1'b0; end
            OP_RDMODE: state <= ST_RMODE;
            OP_WRMODE: state <= ST_WMODE;
            default:   state <= ST_DONE;
          endcase
        end
        ST_ADDR: begin
          cur_addr  <= ADDR_BITS'({cur_addr, rx_byte});
          abyte_cnt <= abyte_cnt + 2'd1;
          if (abyte_cnt == 2'd2) state <= is_read ? ST_RDATA : ST_WDATA;
        end
        ST_WDATA, ST_RDATA: begin
          cur_addr <= step_addr(cur_addr, mode);
          if (single_shot(mode)) state <= ST_DONE;
        end
        ST_WMODE: begin
          mode  <= acc_mode_e'(rx_byte[7:6]);
          state <= ST_DONE;
        end
        ST_RMODE: state <= ST_DONE;
        default:  state <= ST_DONE;
      endcase
    end
  end

  AST_DESELECT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (state == ST_OPCODE)); // R9
  AST_DONE_IS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && sel) |=> (state == ST_DONE)); // R6
  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && mode == AM_PAGE && (state == ST_WDATA || state == ST_RDATA))
      |=> (cur_addr[ADDR_BITS-1:PAGE_BITS] == $past(cur_addr[ADDR_BITS-1:PAGE_BITS]))); // R5

endmodule

// File: rtl/spi_sram_model.sv
module spi_sram_model #(
  parameter int ADDR_BITS = 11,
  parameter int PAGE_BITS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  input  logic hold_n,
  output logic miso,
  output logic miso_oe
);

  logic                 sel, live, byte_done, talking, mem_we, miso_bit;
  logic [7:0]           rx_byte, tx_byte, rd_data, mem_wdata;
  logic [ADDR_BITS-1:0] mem_addr;

  spi_bit_engine u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .hold_n   (hold_n),
    .tx_byte  (tx_byte),
    .sel      (sel),
    .live     (live),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .miso_bit (miso_bit)
  );

  sram_cmd_ctrl #(.ADDR_BITS(ADDR_BITS), .PAGE_BITS(PAGE_BITS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .rd_data  (rd_data),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .tx_byte  (tx_byte),
    .talking  (talking)
  );

  sram_store #(.ADDR_BITS(ADDR_BITS)) u_store (
    .clk  (clk),
    .we   (mem_we),
    .addr (mem_addr),
    .wdata(mem_wdata),
    .rdata(rd_data)
  );

  assign miso    = miso_bit;
  assign miso_oe = talking && live;

  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> ($past(!cs_n) && $past(hold_n))); // R11
  AST_OE_OFF_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_n) |=> !miso_oe); // R10

endmodule

// File: tb/test_spi_sram_model.sv
module test_spi_sram_model;

  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1;
  logic miso, miso_oe;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] rbuf [4];

  always #10 clk = ~clk;

  spi_sram_model #(.ADDR_BITS(AW)) i_spi_sram_model (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .hold_n(hold_n), .miso(miso), .miso_oe(miso_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) mosi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] dummy;
    xfer(tx, dummy);
  endtask

  task automatic open_cs();
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic close_cs();
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic mem_wr(input logic [23:0] a, input int n,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    open_cs();
    send(8'h02);
    send_addr(a);
    send(d0);
    if (n > 1) send(d1);
    if (n > 2) send(d2);
    close_cs();
  endtask

  task automatic mem_rd(input logic [23:0] a, input int n);
    open_cs();
    send(8'h03);
    send_addr(a);
    for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
    close_cs();
  endtask

  task automatic set_mode(input logic [7:0] v);
    open_cs(); send(8'h01); send(v); close_cs();
  endtask

  task automatic get_mode(output logic [7:0] v);
    open_cs(); send(8'h05); xfer(8'h00, v); close_cs();
  endtask

  task automatic t_reset();
    logic [7:0] m;
    chk("R1 oe after reset", miso_oe, 0);
    get_mode(m);
    chk("R1 default mode", m, 8'h40);
  endtask

  task automatic t_basic();
    logic [7:0] r;
    open_cs();
    send(8'h02); send_addr(24'hFC0123); send(8'hA5);
    chk("R11 oe low in write", miso_oe, 0);
    close_cs();
    open_cs();
    send(8'h03);
    chk("R11 oe low in address", miso_oe, 0);
    send_addr(24'h000123);
    xfer(8'h00, r);
    chk("R2 aliased read", r, 8'hA5);
    chk("R11 oe high in read", miso_oe, 1);
    close_cs();
    chk("R11 oe low deselected", miso_oe, 0);
  endtask

  task automatic t_seq();
    open_cs();
    send(8'h02); send_addr(24'h00001E);
    send(8'h11); send(8'h12); send(8'h13); send(8'h14);
    close_cs();
    mem_rd(24'h00001E, 4);
    chk("R3 seq byte0", rbuf[0], 8'h11);
    chk("R3 seq byte1", rbuf[1], 8'h12);
    chk("R3 seq byte2 next page", rbuf[2], 8'h13);
    chk("R3 seq byte3", rbuf[3], 8'h14);
  endtask

  task automatic t_wrap();
    mem_wr(24'h0003FF, 2, 8'h55, 8'h66, 8'h00);
    mem_rd(24'h000000, 1);
    chk("R4 wrap write to 0", rbuf[0], 8'h66);
    mem_rd(24'h0003FF, 2);
    chk("R4 wrap read last", rbuf[0], 8'h55);
    chk("R4 wrap read first", rbuf[1], 8'h66);
  endtask

  task automatic t_page();
    logic [7:0] m;
    mem_wr(24'h000040, 1, 8'hEE, 8'h00, 8'h00);
    set_mode(8'h80);
    get_mode(m);
    chk("R7 page mode readback", m, 8'h80);
    mem_wr(24'h00003F, 3, 8'hA1, 8'hA2, 8'hA3);
    mem_rd(24'h00003F, 3);
    chk("R5 page offset 31", rbuf[0], 8'hA1);
    chk("R5 page wrap to 0", rbuf[1], 8'hA2);
    chk("R5 page wrap to 1", rbuf[2], 8'hA3);
    set_mode(8'h40);
    mem_rd(24'h000020, 2);
    chk("R5 page base", rbuf[0], 8'hA2);
    chk("R5 page base+1", rbuf[1], 8'hA3);
    mem_rd(24'h000040, 1);
    chk("R5 next page untouched", rbuf[0], 8'hEE);
  endtask

  task automatic t_byte();
    logic [7:0] r;
    mem_wr(24'h000100, 2, 8'h77, 8'h78, 8'h00);
    set_mode(8'h00);
    mem_wr(24'h000100, 2, 8'h90, 8'h91, 8'h00);
    open_cs();
    send(8'h03); send_addr(24'h000100);
    xfer(8'h00, r);
    chk("R6 byte read", r, 8'h90);
    send(8'h00);
    chk("R6 oe low after one byte", miso_oe, 0);
    close_cs();
    set_mode(8'h40);
    mem_rd(24'h000100, 2);
    chk("R6 first byte written", rbuf[0], 8'h90);
    chk("R6 second byte ignored", rbuf[1], 8'h78);
  endtask

  task automatic t_mode();
    logic [7:0] m;
    set_mode(8'hBF);
    get_mode(m);
    chk("R7 reserved bits drop", m, 8'h80);
    set_mode(8'h40);
    get_mode(m);
    chk("R7 back to sequential", m, 8'h40);
  endtask

  task automatic t_ignored();
    logic [7:0] m;
    mem_wr(24'h000010, 1, 8'h5A, 8'h00, 8'h00);
    open_cs();
    send(8'h3B); send(8'h02); send_addr(24'h000010); send(8'hAB);
    chk("R8 oe low after 0x3B", miso_oe, 0);
    close_cs();
    open_cs(); send(8'h38); send(8'h01); send(8'h80); close_cs();
    open_cs(); send(8'hFF); send(8'h01); send(8'h00); close_cs();
    get_mode(m);
    chk("R8 mode unchanged", m, 8'h40);
    mem_rd(24'h000010, 1);
    chk("R8 array unchanged", rbuf[0], 8'h5A);
  endtask

  task automatic t_abort();
    mem_wr(24'h000200, 2, 8'h00, 8'h3C, 8'h00);
    open_cs();
    send(8'h02); send_addr(24'h000200); send(8'hC1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) mosi = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    close_cs();
    open_cs(); send(8'h03); send(8'h00); close_cs();
    mem_rd(24'h000200, 2);
    chk("R9 full byte kept", rbuf[0], 8'hC1);
    chk("R9 partial byte dropped", rbuf[1], 8'h3C);
  endtask

  task automatic t_hold();
    logic [7:0] r;
    mem_wr(24'h000300, 2, 8'hD1, 8'hD2, 8'h00);
    open_cs();
    send(8'h03); send_addr(24'h000300);
    xfer(8'h00, r);
    chk("R10 byte before hold", r, 8'hD1);
    @(negedge clk) hold_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 oe low in hold", miso_oe, 0);
    send(8'hFF);
    @(negedge clk) hold_n = 1'b1;
    repeat (3) @(negedge clk);
    xfer(8'h00, r);
    chk("R10 resumed byte", r, 8'hD2);
    close_cs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_seq();
    t_wrap();
    t_page();
    t_byte();
    t_mode();
    t_ignored();
    t_abort();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule